// File: doc/BRIEF.md
# DRBG Instance Working-State Store

This block keeps the working state of several counter-mode deterministic random bit generator instances. Each instance has one record: a request counter, a 128-bit chaining value V, a 256-bit cipher key, an "instantiated" bit and a "compliant seed" bit. The processing pipeline reads the record of any instance combinationally. When a command has been computed, the pipeline hands back a write-back that carries the instance number, the command code, the new V and key, and the compliance of the seed.

The store applies rules that depend on the command. Some commands set the counter back to one and others advance it. Some record the compliance flag, and some leave it as it was. Uninstantiate clears the whole record. A command that needs a live instance is refused when the instance is not instantiated. Every write-back is answered one cycle later by a single-cycle accept pulse or a single-cycle reject pulse.

A gated debug port returns the V and key of a selected instance as 32-bit words. Computing V and key and fetching entropy belong to other blocks.

Top module: `drbg_state_store`

## Requirements
- R1: While reset is active (synchronous, active low) every record is cleared to all zeros, and neither the accept output nor the reject output is high in the cycle after reset.
- R2: A write-back presented at a clock edge is answered in the next cycle by exactly one of `wb_ack_o` or `wb_err_o`, each high for one cycle. Any record change it causes is visible on the read port from that same cycle. Command codes: 1 instantiate, 2 reseed, 3 generate, 4 update, 5 uninstantiate.
- R3: Instantiate is accepted in any state. It writes V and key, sets the counter to 1, sets the instantiated bit and copies the compliance input into the compliance bit.
- R4: Reseed of an instantiated instance writes V and key, sets the counter to 1 and copies the compliance input.
- R5: Generate of an instantiated instance writes V and key and adds one to the counter, which saturates at 2^CTR_W-1. The compliance bit is not changed.
- R6: Update of an instantiated instance writes V and key and leaves both the counter and the compliance bit unchanged.
- R7: Reseed, generate or update aimed at an instance whose instantiated bit is clear is rejected, and that record is left unchanged.
- R8: Uninstantiate is accepted in any state and sets every field of the record to zero, including the instantiated bit.
- R9: Command codes 0, 6 and 7 are rejected and change no record.
- R10: A write-back changes only the record of the instance it names.
- R11: Debug word index 0..3 returns V from least to most significant 32 bits. Index 4..11 returns the key in the same order. Index 12..15 returns zero. When `dbg_en_i` is low the debug data is zero for any index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid_i | input | 1 | Write-back present this cycle |
| wb_inst_i | input | IDX_W | Instance the write-back targets |
| wb_cmd_i | input | 3 | Command that produced the write-back |
| wb_v_i | input | V_W | New chaining value |
| wb_key_i | input | KEY_W | New cipher key |
| wb_fips_i | input | 1 | Seed compliance for instantiate and reseed |
| wb_ack_o | output | 1 | Write-back accepted (one-cycle pulse) |
| wb_err_o | output | 1 | Write-back rejected (one-cycle pulse) |
| rd_inst_i | input | IDX_W | Instance read by the pipeline |
| rd_ctr_o | output | CTR_W | Request counter of the read instance |
| rd_v_o | output | V_W | V of the read instance |
| rd_key_o | output | KEY_W | Key of the read instance |
| rd_live_o | output | 1 | Instantiated bit of the read instance |
| rd_fips_o | output | 1 | Compliance bit of the read instance |
| dbg_en_i | input | 1 | Debug read enable |
| dbg_inst_i | input | IDX_W | Instance for the debug read |
| dbg_word_i | input | DBG_IDX_W | 32-bit word index for the debug read |
| dbg_data_o | output | 32 | Debug read data |

## Verification
The hardest condition to reach is counter saturation. At the default 32-bit width it would take billions of generate write-backs. The bench therefore builds the block with a 4-bit counter and issues more than fifteen generates to one instance, which drives the counter into its ceiling and keeps it there.

Rejected write-backs are checked by reading the targeted record back through the pipeline read port. The bench compares it with the value the record held before the refused command. It uses two cases: an instance that was never instantiated, and a live instance that receives an unused command code.

// File: rtl/drbg_store_pkg.sv
// Package: shared command encoding of the working-state store.
// Assumes write-back producers use these 3-bit codes; other codes are illegal.
package drbg_store_pkg;
    typedef enum logic [2:0] {
        DCMD_NONE   = 3'd0,
        DCMD_INST   = 3'd1,
        DCMD_RESEED = 3'd2,
        DCMD_GEN    = 3'd3,
        DCMD_UPDATE = 3'd4,
        DCMD_UNINST = 3'd5
    } drbg_cmd_e;

    localparam int unsigned DBG_WORD_W = 32;
endpackage

// File: rtl/drbg_rec_rule.sv
// Module: computes the next record of one instance from its current record and
// a write-back. Purely combinational. Record layout from LSB:
// counter, V, key, instantiated bit, compliance bit.
// Assumes the caller commits nxt_rec_o only when accept_o is high.
module drbg_rec_rule
    import drbg_store_pkg::*;
#(
    parameter int unsigned CTR_W = 32,
    parameter int unsigned V_W   = 128,
    parameter int unsigned KEY_W = 256,
    localparam int unsigned REC_W = CTR_W + V_W + KEY_W + 2
) (
    input  logic [2:0]       cmd_i,
    input  logic [REC_W-1:0] cur_rec_i,
    input  logic [V_W-1:0]   new_v_i,
    input  logic [KEY_W-1:0] new_key_i,
    input  logic             new_fips_i,
    output logic [REC_W-1:0] nxt_rec_o,
    output logic             accept_o
);
    localparam int unsigned V_LO    = CTR_W;
    localparam int unsigned KEY_LO  = CTR_W + V_W;
    localparam int unsigned LIVE_B  = CTR_W + V_W + KEY_W;
    localparam int unsigned FIPS_B  = LIVE_B + 1;
    localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

    logic [CTR_W-1:0] cur_ctr;
    logic             cur_live;
    logic             cur_fips;
    logic [CTR_W-1:0] ctr_inc;

    assign cur_ctr  = cur_rec_i[CTR_W-1:0];
    assign cur_live = cur_rec_i[LIVE_B];
    assign cur_fips = cur_rec_i[FIPS_B];

    // Saturating increment of the request counter.
    always_comb begin
        ctr_inc = (&cur_ctr) ? cur_ctr : cur_ctr + CTR_ONE;
    end

    // Command-specific next-record selection and acceptance.
    always_comb begin
        nxt_rec_o = cur_rec_i;
        accept_o  = 1'b0;
        case (cmd_i)
            DCMD_INST: begin
                accept_o = 1'b1;
                nxt_rec_o = {new_fips_i, 1'b1, new_key_i, new_v_i, CTR_ONE};
            end
            DCMD_RESEED: begin
                accept_o = cur_live;
                nxt_rec_o = {new_fips_i, 1'b1, new_key_i, new_v_i, CTR_ONE};
            end
            DCMD_GEN: begin
                accept_o = cur_live;
                nxt_rec_o = {cur_fips, 1'b1, new_key_i, new_v_i, ctr_inc};
            end
            DCMD_UPDATE: begin
                accept_o = cur_live;
                nxt_rec_o = {cur_fips, 1'b1, new_key_i, new_v_i, cur_ctr};
            end
            DCMD_UNINST: begin
                accept_o = 1'b1;
                nxt_rec_o = '0;
            end
            default: begin
                accept_o = 1'b0;
            end
        endcase
    end

    // Field offsets kept for readers of the layout.
    logic unused_layout;
    assign unused_layout = ^{V_LO[0], KEY_LO[0]};
endmodule

// File: rtl/drbg_rec_bank.sv
// Module: register bank holding one record per instance, all visible at once.
// Assumes at most one write per cycle; synchronous active-low reset zeroes all.
module drbg_rec_bank #(
    parameter int unsigned NUM_INST = 4,
    parameter int unsigned REC_W    = 418,
    localparam int unsigned IDX_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [IDX_W-1:0]               widx_i,
    input  logic [REC_W-1:0]               wdata_i,
    output logic [NUM_INST-1:0][REC_W-1:0] rec_o
);
    for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_slot
        logic [REC_W-1:0] slot_q;

        // Hold one instance record; load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we_i && (widx_i == IDX_W'(gi))) begin
                slot_q <= wdata_i;
            end
        end

        assign rec_o[gi] = slot_q;
    end
endmodule

// File: rtl/drbg_dbg_read.sv
// Module: gated debug view of one record as 32-bit words, V words first
// (low to high) then key words. Out-of-range indices and a low enable give zero.
module drbg_dbg_read
    import drbg_store_pkg::*;
#(
    parameter int unsigned V_W   = 128,
    parameter int unsigned KEY_W = 256,
    localparam int unsigned NWORDS    = (V_W + KEY_W) / DBG_WORD_W,
    localparam int unsigned DBG_IDX_W = $clog2(NWORDS)
) (
    input  logic                  en_i,
    input  logic [DBG_IDX_W-1:0]  word_i,
    input  logic [V_W-1:0]        v_i,
    input  logic [KEY_W-1:0]      key_i,
    output logic [DBG_WORD_W-1:0] data_o
);
    logic [NWORDS-1:0][DBG_WORD_W-1:0] words;

    assign words = {key_i, v_i};

    // Select the requested word when enabled and in range.
    always_comb begin
        data_o = '0;
        if (en_i && (32'(word_i) < NWORDS)) begin
            data_o = words[word_i];
        end
    end
endmodule

// File: rtl/drbg_state_store.sv
// Module: top of the multi-instance DRBG working-state store.
// Applies command rules to write-backs, answers each with one accept or reject
// pulse a cycle later, and offers a combinational pipeline read plus a gated
// debug read. Assumes one write-back per cycle at most.
module drbg_state_store
    import drbg_store_pkg::*;
#(
    parameter int unsigned NUM_INST = 4,
    parameter int unsigned CTR_W    = 32,
    parameter int unsigned V_W      = 128,
    parameter int unsigned KEY_W    = 256,
    localparam int unsigned IDX_W     = (NUM_INST > 1) ? $clog2(NUM_INST) : 1,
    localparam int unsigned REC_W     = CTR_W + V_W + KEY_W + 2,
    localparam int unsigned DBG_IDX_W = $clog2((V_W + KEY_W) / DBG_WORD_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wb_valid_i,
    input  logic [IDX_W-1:0]      wb_inst_i,
    input  logic [2:0]            wb_cmd_i,
    input  logic [V_W-1:0]        wb_v_i,
    input  logic [KEY_W-1:0]      wb_key_i,
    input  logic                  wb_fips_i,
    output logic                  wb_ack_o,
    output logic                  wb_err_o,
    input  logic [IDX_W-1:0]      rd_inst_i,
    output logic [CTR_W-1:0]      rd_ctr_o,
    output logic [V_W-1:0]        rd_v_o,
    output logic [KEY_W-1:0]      rd_key_o,
    output logic                  rd_live_o,
    output logic                  rd_fips_o,
    input  logic                  dbg_en_i,
    input  logic [IDX_W-1:0]      dbg_inst_i,
    input  logic [DBG_IDX_W-1:0]  dbg_word_i,
    output logic [DBG_WORD_W-1:0] dbg_data_o
);
    localparam int unsigned V_LO   = CTR_W;
    localparam int unsigned KEY_LO = CTR_W + V_W;
    localparam int unsigned LIVE_B = CTR_W + V_W + KEY_W;
    localparam int unsigned FIPS_B = LIVE_B + 1;

    logic [NUM_INST-1:0][REC_W-1:0] rec_all;
    logic [REC_W-1:0] cur_rec;
    logic [REC_W-1:0] nxt_rec;
    logic             accept;
    logic             we;
    logic [REC_W-1:0] rd_rec;
    logic [REC_W-1:0] dbg_rec;
    logic             ack_q;
    logic             err_q;
    logic [2:0]       cmd_q;
    logic [IDX_W-1:0] inst_q;
    logic [REC_W-1:0] snap_q;

    assign cur_rec = rec_all[wb_inst_i];
    assign we      = wb_valid_i && accept;

    drbg_rec_rule #(
        .CTR_W (CTR_W),
        .V_W   (V_W),
        .KEY_W (KEY_W)
    ) i_rule (
        .cmd_i      (wb_cmd_i),
        .cur_rec_i  (cur_rec),
        .new_v_i    (wb_v_i),
        .new_key_i  (wb_key_i),
        .new_fips_i (wb_fips_i),
        .nxt_rec_o  (nxt_rec),
        .accept_o   (accept)
    );

    drbg_rec_bank #(
        .NUM_INST (NUM_INST),
        .REC_W    (REC_W)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .widx_i  (wb_inst_i),
        .wdata_i (nxt_rec),
        .rec_o   (rec_all)
    );

    // Register the response pulses and the context of the last write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            cmd_q  <= '0;
            inst_q <= '0;
            snap_q <= '0;
        end else begin
            ack_q  <= wb_valid_i && accept;
            err_q  <= wb_valid_i && !accept;
            cmd_q  <= wb_cmd_i;
            inst_q <= wb_inst_i;
            snap_q <= cur_rec;
        end
    end

    assign wb_ack_o = ack_q;
    assign wb_err_o = err_q;

    // Pipeline read: split the selected record into fields.
    assign rd_rec    = rec_all[rd_inst_i];
    assign rd_ctr_o  = rd_rec[CTR_W-1:0];
    assign rd_v_o    = rd_rec[V_LO +: V_W];
    assign rd_key_o  = rd_rec[KEY_LO +: KEY_W];
    assign rd_live_o = rd_rec[LIVE_B];
    assign rd_fips_o = rd_rec[FIPS_B];

    assign dbg_rec = rec_all[dbg_inst_i];

    drbg_dbg_read #(
        .V_W   (V_W),
        .KEY_W (KEY_W)
    ) i_dbg (
        .en_i   (dbg_en_i),
        .word_i (dbg_word_i),
        .v_i    (dbg_rec[V_LO +: V_W]),
        .key_i  (dbg_rec[KEY_LO +: KEY_W]),
        .data_o (dbg_data_o)
    );

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_i |=> (wb_ack_o != wb_err_o)); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid_i |=> (!wb_ack_o && !wb_err_o)); // R2
    AST_INST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_o && cmd_q == DCMD_INST) |->
            (rec_all[inst_q][LIVE_B] && rec_all[inst_q][CTR_W-1:0] == CTR_W'(1))); // R3
    AST_GEN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_o && cmd_q == DCMD_GEN) |->
            (rec_all[inst_q][CTR_W-1:0] != '0 &&
             rec_all[inst_q][CTR_W-1:0] >= snap_q[CTR_W-1:0])); // R5
    AST_UPD_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_o && cmd_q == DCMD_UPDATE) |->
            (rec_all[inst_q][CTR_W-1:0] == snap_q[CTR_W-1:0])); // R6
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err_o |-> (rec_all[inst_q] == snap_q)); // R7
    AST_UNINST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_o && cmd_q == DCMD_UNINST) |-> (rec_all[inst_q] == '0)); // R8
    AST_DBG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en_i |-> (dbg_data_o == '0)); // R11
endmodule

// File: tb/test_drbg_state_store.sv
module test_drbg_state_store;
    localparam int CLK_PERIOD = 10;
    localparam int NI   = 4;
    localparam int CW   = 4;
    localparam int VW   = 128;
    localparam int KW   = 256;
    localparam int IW   = 2;
    localparam int NVEC = 16;

    // Vector fields: [28:26] cmd, [25:24] inst, [23] fips, [22:15] seed,
    // [14] exp reject, [13:10] exp counter, [9] exp live, [8] exp fips, [7:0] exp V seed
    localparam logic [28:0] VEC [NVEC] = '{
        {3'd3, 2'd0, 1'b0, 8'h00, 1'b1, 4'd0, 1'b0, 1'b0, 8'h00}, // R7 gen on empty
        {3'd1, 2'd0, 1'b1, 8'h11, 1'b0, 4'd1, 1'b1, 1'b1, 8'h11}, // R3
        {3'd3, 2'd0, 1'b0, 8'h22, 1'b0, 4'd2, 1'b1, 1'b1, 8'h22}, // R5
        {3'd3, 2'd0, 1'b0, 8'h33, 1'b0, 4'd3, 1'b1, 1'b1, 8'h33}, // R5
        {3'd4, 2'd0, 1'b0, 8'h44, 1'b0, 4'd3, 1'b1, 1'b1, 8'h44}, // R6
        {3'd2, 2'd0, 1'b0, 8'h55, 1'b0, 4'd1, 1'b1, 1'b0, 8'h55}, // R4
        {3'd2, 2'd1, 1'b1, 8'h66, 1'b1, 4'd0, 1'b0, 1'b0, 8'h00}, // R7 reseed on empty
        {3'd4, 2'd1, 1'b1, 8'h67, 1'b1, 4'd0, 1'b0, 1'b0, 8'h00}, // R7 update on empty
        {3'd1, 2'd1, 1'b0, 8'h77, 1'b0, 4'd1, 1'b1, 1'b0, 8'h77}, // R3
        {3'd3, 2'd1, 1'b1, 8'h88, 1'b0, 4'd2, 1'b1, 1'b0, 8'h88}, // R5 fips kept
        {3'd5, 2'd0, 1'b0, 8'h00, 1'b0, 4'd0, 1'b0, 1'b0, 8'h00}, // R8
        {3'd3, 2'd0, 1'b0, 8'h99, 1'b1, 4'd0, 1'b0, 1'b0, 8'h00}, // R7 after uninst
        {3'd1, 2'd3, 1'b1, 8'hAA, 1'b0, 4'd1, 1'b1, 1'b1, 8'hAA}, // R3
        {3'd6, 2'd3, 1'b0, 8'hBB, 1'b1, 4'd1, 1'b1, 1'b1, 8'hAA}, // R9
        {3'd5, 2'd2, 1'b0, 8'h00, 1'b0, 4'd0, 1'b0, 1'b0, 8'h00}, // R8 on empty
        {3'd3, 2'd1, 1'b0, 8'h9C, 1'b0, 4'd3, 1'b1, 1'b0, 8'h9C}  // R10 inst1 intact
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wb_valid = 1'b0;
    logic [IW-1:0] wb_inst = '0;
    logic [2:0]    wb_cmd = '0;
    logic [VW-1:0] wb_v = '0;
    logic [KW-1:0] wb_key = '0;
    logic          wb_fips = 1'b0;
    logic          wb_ack;
    logic          wb_err;
    logic [IW-1:0] rd_inst = '0;
    logic [CW-1:0] rd_ctr;
    logic [VW-1:0] rd_v;
    logic [KW-1:0] rd_key;
    logic          rd_live;
    logic          rd_fips;
    logic          dbg_en = 1'b0;
    logic [IW-1:0] dbg_inst = '0;
    logic [3:0]    dbg_word = '0;
    logic [31:0]   dbg_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic got_ack;
    logic got_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    drbg_state_store #(
        .NUM_INST (NI),
        .CTR_W    (CW),
        .V_W      (VW),
        .KEY_W    (KW)
    ) i_drbg_state_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wb_valid_i (wb_valid),
        .wb_inst_i  (wb_inst),
        .wb_cmd_i   (wb_cmd),
        .wb_v_i     (wb_v),
        .wb_key_i   (wb_key),
        .wb_fips_i  (wb_fips),
        .wb_ack_o   (wb_ack),
        .wb_err_o   (wb_err),
        .rd_inst_i  (rd_inst),
        .rd_ctr_o   (rd_ctr),
        .rd_v_o     (rd_v),
        .rd_key_o   (rd_key),
        .rd_live_o  (rd_live),
        .rd_fips_o  (rd_fips),
        .dbg_en_i   (dbg_en),
        .dbg_inst_i (dbg_inst),
        .dbg_word_i (dbg_word),
        .dbg_data_o (dbg_data)
    );

    task automatic check(input bit pass, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (!pass) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // One write-back; leaves response captured, inputs idle, at a negedge.
    task automatic wb(input logic [2:0] cmd, input logic [IW-1:0] inst,
                      input logic fips, input logic [7:0] seed);
        @(negedge clk);
        wb_valid = 1'b1;
        wb_cmd   = cmd;
        wb_inst  = inst;
        wb_fips  = fips;
        wb_v     = {16{seed}};
        wb_key   = {32{seed ^ 8'h5A}};
        @(negedge clk);
        wb_valid = 1'b0;
        got_ack  = wb_ack;
        got_err  = wb_err;
    endtask

    task automatic check_rec(input string tag, input logic [IW-1:0] inst,
                             input logic [CW-1:0] ectr, input logic elive,
                             input logic efips, input logic [7:0] vs);
        logic [VW-1:0] ev;
        logic [KW-1:0] ek;
        ev = elive ? {16{vs}} : '0;
        ek = elive ? {32{vs ^ 8'h5A}} : '0;
        rd_inst = inst;
        #1;
        check(rd_ctr == ectr, {tag, " counter"}, 256'(rd_ctr), 256'(ectr));
        check(rd_live == elive, {tag, " live"}, 256'(rd_live), 256'(elive));
        check(rd_fips == efips, {tag, " fips"}, 256'(rd_fips), 256'(efips));
        check(rd_v == ev, {tag, " V"}, 256'(rd_v), 256'(ev));
        check(rd_key == ek, {tag, " key"}, rd_key, ek);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!wb_ack && !wb_err, "R1 no response after reset",
              256'({wb_ack, wb_err}), 256'(0));
        for (int i = 0; i < NI; i++) check_rec("R1 reset record", IW'(i), '0, 1'b0, 1'b0, 8'h00);

        // Table walk: R2..R10
        for (int k = 0; k < NVEC; k++) begin
            logic [28:0] e;
            e = VEC[k];
            wb(e[28:26], e[25:24], e[23], e[22:15]);
            check(got_err == e[14] && got_ack == !e[14],
                  $sformatf("R2 response vec %0d", k),
                  256'({got_ack, got_err}), 256'({!e[14], e[14]}));
            check_rec($sformatf("R3-R10 vec %0d", k), e[25:24], e[13:10], e[9], e[8], e[7:0]);
        end

        // R10: untouched instance 2 stays empty, inst 3 intact
        check_rec("R10 inst2", 2'd2, '0, 1'b0, 1'b0, 8'h00);
        check_rec("R10 inst3", 2'd3, 4'd1, 1'b1, 1'b1, 8'hAA);

        // R11: debug read of instance 3
        dbg_inst = 2'd3;
        dbg_en = 1'b1;
        dbg_word = 4'd0;  #1;
        check(dbg_data == 32'hAAAAAAAA, "R11 V word0", 256'(dbg_data), 256'(32'hAAAAAAAA));
        dbg_word = 4'd3;  #1;
        check(dbg_data == 32'hAAAAAAAA, "R11 V word3", 256'(dbg_data), 256'(32'hAAAAAAAA));
        dbg_word = 4'd4;  #1;
        check(dbg_data == 32'hF0F0F0F0, "R11 key word0", 256'(dbg_data), 256'(32'hF0F0F0F0));
        dbg_word = 4'd11; #1;
        check(dbg_data == 32'hF0F0F0F0, "R11 key word7", 256'(dbg_data), 256'(32'hF0F0F0F0));
        dbg_word = 4'd12; #1;
        check(dbg_data == 32'h0, "R11 out of range", 256'(dbg_data), 256'(0));
        dbg_word = 4'd4;
        dbg_en = 1'b0; #1;
        check(dbg_data == 32'h0, "R11 disabled", 256'(dbg_data), 256'(0));

        // R11: debug word order distinguishes low and high words
        wb(3'd4, 2'd3, 1'b0, 8'hC3);
        dbg_en = 1'b1;
        dbg_word = 4'd1; #1;
        check(dbg_data == 32'hC3C3C3C3, "R11 V word1 after update", 256'(dbg_data), 256'(32'hC3C3C3C3));
        dbg_en = 1'b0;

        // R5: counter saturation on instance 2
        wb(3'd1, 2'd2, 1'b1, 8'h10);
        for (int g = 0; g < 20; g++) begin
            wb(3'd3, 2'd2, 1'b0, 8'(g));
            if (g == 13) check_rec("R5 counter at 15", 2'd2, 4'd15, 1'b1, 1'b1, 8'(g));
        end
        check(got_ack && !got_err, "R5 saturated generate accepted",
              256'({got_ack, got_err}), 256'(2'b10));
        check_rec("R5 counter saturated", 2'd2, 4'd15, 1'b1, 1'b1, 8'd19);
        wb(3'd2, 2'd2, 1'b0, 8'h21);
        check_rec("R4 reseed clears saturation", 2'd2, 4'd1, 1'b1, 1'b0, 8'h21);

        // R9: code 7 and code 0 rejected on live instance
        wb(3'd7, 2'd2, 1'b1, 8'h31);
        check(got_err && !got_ack, "R9 code 7 rejected", 256'({got_ack, got_err}), 256'(2'b01));
        wb(3'd0, 2'd2, 1'b1, 8'h32);
        check(got_err && !got_ack, "R9 code 0 rejected", 256'({got_ack, got_err}), 256'(2'b01));
        check_rec("R9 record kept", 2'd2, 4'd1, 1'b1, 1'b0, 8'h21);

        // R3: instantiate over a live instance
        wb(3'd1, 2'd2, 1'b1, 8'h41);
        check_rec("R3 re-instantiate", 2'd2, 4'd1, 1'b1, 1'b1, 8'h41);

        // R2: idle cycle gives no response
        @(negedge clk);
        check(!wb_ack && !wb_err, "R2 idle quiet", 256'({wb_ack, wb_err}), 256'(0));

        // R1: reset mid-run clears every record
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NI; i++) check_rec("R1 reset again", IW'(i), '0, 1'b0, 1'b0, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule